// File: doc/BRIEF.md
# Core Stack Access Sequencer

This block runs every access to an eight-plane stack of magnetic cores in which each plane is a 64 by 64 grid. All planes share one set of X and Y select lines, so one access touches the same bit position in every plane and together they form an 8-bit word. Reading a core destroys its content. A read therefore drives the selected position in all planes toward zero and watches eight sense inputs for the pulse that a flipping core produces. The sensed word is latched into an internal data register. The block then writes the lost ones back without any help from the host.

The write-back is serial. After a gap, each plane whose latched bit is one receives its own drive pulse with one-polarity, and planes that read zero are skipped. A host write uses the same path. It clears the location in all planes, loads the data register from the write data, and then the same serial sequencer drives a one into each plane whose bit is set. The host sees a request/ready handshake with an address, write data and read data. Drive pulse length, the gap between drives, and the sense sampling window are all parameters.

Top module: `core_stack_ctrl`

## Requirements
- R1: For the whole of an access, `col_sel` carries address bits [11:6] and `row_sel` carries address bits [5:0] of the accepted request. Both stay unchanged until `ready` returns.
- R2: After reset, `ready` is 1, `plane_drv` is 0 and `rdata` is 0.
- R3: A request is accepted on a clock edge where `req` and `ready` are both 1. From the next cycle `ready` is 0 until the access ends. `req` is ignored while `ready` is 0, and no drive occurs while `ready` is 1.
- R4: The first `PULSE_CYC` cycles of every access are the clear phase. In it, `plane_drv` has all bits set and `drive_one` is 0.
- R5: On a read, a plane's `sense` bit is captured only in clear-phase cycles numbered `WIN_LO` to `WIN_HI`, with the first clear cycle counted as 0. Pulses in any other cycle, and all pulses during a write, have no effect.
- R6: After a read ends, `rdata` holds the captured word (bit i = plane i). It keeps that value until the next accepted request.
- R7: After the clear phase, each plane whose data-register bit is 1 gets one restore drive, in ascending plane order. A restore drive is `PULSE_CYC` cycles with only that plane's `plane_drv` bit set and `drive_one` = 1. Planes whose bit is 0 get no drive.
- R8: Every drive phase, clear or restore, is followed by `GAP_CYC` cycles with `plane_drv` = 0. An access with n ones to restore keeps `ready` low for exactly (n+1)*(PULSE_CYC+GAP_CYC) cycles.
- R9: A write loads `wdata` into the data register, clears the location, then drives ones into the planes whose `wdata` bit is set, as in R7. Afterwards `rdata` equals `wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Column index [11:6], row index [5:0] |
| wdata | input | 8 | Write word, bit i to plane i |
| rdata | output | 8 | Data register contents |
| ready | output | 1 | Idle and able to accept a request |
| col_sel | output | 6 | Shared X line index |
| row_sel | output | 6 | Shared Y line index |
| plane_drv | output | 8 | Per-plane drive enable |
| drive_one | output | 1 | Drive polarity: 1 writes a one, 0 writes a zero |
| sense | input | 8 | Per-plane sense pulse |

## Verification
The bench models the core stack. It checks every cycle of each access against a drive schedule that it computes itself, so a restore in the wrong order, a restore of a zero plane, a missing gap, or overlapping drives all show up as a schedule mismatch. Reading the same location twice exposes a design that forgets to restore, because the second read would then return zero. Sense pulses placed only outside the window, and pulses that arrive during writes, catch a design that samples for too long or captures during a write. A request held high in the middle of an access catches a design that lets the select lines change or starts a second access.

// File: rtl/core_pkg.sv
// Shared types for the core stack access sequencer.
package core_pkg;
    // Access phases: idle, all-plane clear, inter-drive gap, single-plane one drive.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CLEAR = 2'd1,
        PH_GAP   = 2'd2,
        PH_SET   = 2'd3
    } phase_e;
endpackage

// File: rtl/cs_plane_pick.sv
// Lowest-set-bit selector.
// Returns a one-hot vector for the lowest plane still pending a restore drive.
// Assumes nothing about the input; an all-zero input gives an all-zero result.
module cs_plane_pick #(
    parameter int PLANES = 8
) (
    input  logic [PLANES-1:0] pending,
    output logic [PLANES-1:0] pick
);
    // Scan from the top down so that the lowest set bit wins.
    always_comb begin
        pick = '0;
        for (int i = PLANES - 1; i >= 0; i--) begin
            if (pending[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cs_sense_latch.sv
// Data register, one flip-flop per plane.
// On load it takes a fresh value. While capture is enabled it ORs in the
// sense pulses. Otherwise it holds. data_next is exposed so that the
// sequencer can take the final word in the same cycle as the last capture.
module cs_sense_latch #(
    parameter int PLANES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PLANES-1:0] load_val,
    input  logic              cap_en,
    input  logic [PLANES-1:0] sense,
    output logic [PLANES-1:0] data_q,
    output logic [PLANES-1:0] data_next
);
    // Next value: load has priority over capture.
    always_comb begin
        if (load)        data_next = load_val;
        else if (cap_en) data_next = data_q | sense;
        else             data_next = data_q;
    end

    // Register the data word.
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_next;
    end

    // R5: outside load and the capture window the register must not move.
    a_r5_hold_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !cap_en) |=> $stable(data_q));
endmodule

// File: rtl/cs_sequencer.sv
// Phase sequencer for one access.
// Runs the clear drive, then a gap, then one single-plane drive of
// one-polarity (each followed by a gap) for every pending plane, lowest
// plane first. It assumes PULSE_CYC >= 1 and GAP_CYC >= 1.
module cs_sequencer
    import core_pkg::*;
#(
    parameter int PLANES    = 8,
    parameter int PULSE_CYC = 4,
    parameter int GAP_CYC   = 2,
    parameter int CW        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PLANES-1:0] pend_src,
    output logic              idle,
    output logic              in_clear,
    output logic [CW-1:0]     cnt,
    output logic [PLANES-1:0] plane_drv,
    output logic              drive_one
);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] GAP_LAST   = CW'(GAP_CYC - 1);

    phase_e            phase;
    logic [PLANES-1:0] pend;
    logic [PLANES-1:0] cur;
    logic [PLANES-1:0] pick;

    cs_plane_pick #(.PLANES(PLANES)) u_pick (
        .pending (pend),
        .pick    (pick)
    );

    // Phase, cycle counter and pending-plane bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            pend  <= '0;
            cur   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (start) phase <= PH_CLEAR;
                end
                PH_CLEAR: begin
                    if (cnt == PULSE_LAST) begin
                        phase <= PH_GAP;
                        cnt   <= '0;
                        pend  <= pend_src;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_GAP: begin
                    if (cnt == GAP_LAST) begin
                        cnt <= '0;
                        if (pend == '0) begin
                            phase <= PH_IDLE;
                        end else begin
                            phase <= PH_SET;
                            cur   <= pick;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_SET: begin
                    if (cnt == PULSE_LAST) begin
                        phase <= PH_GAP;
                        cnt   <= '0;
                        pend  <= pend & ~cur;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Drive outputs decoded from the phase.
    always_comb begin
        idle      = (phase == PH_IDLE);
        in_clear  = (phase == PH_CLEAR);
        drive_one = (phase == PH_SET);
        case (phase)
            PH_CLEAR: plane_drv = '1;
            PH_SET:   plane_drv = cur;
            default:  plane_drv = '0;
        endcase
    end

    // R8: two drive phases never touch. A non-zero drive that follows a
    // non-zero drive must be the same phase continuing.
    a_r8_no_drive_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        ((plane_drv != '0) && ($past(plane_drv) != '0)) |-> (plane_drv == $past(plane_drv)));

    // R7: a one-polarity drive always moves exactly one plane.
    a_r7_one_plane_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        drive_one |-> ($countones(plane_drv) == 1));
endmodule

// File: rtl/core_stack_ctrl.sv
// Core stack access controller, top level.
// Accepts one read or write at a time and latches the address and
// direction. It runs the clear / capture / serial one-drive sequence and
// holds the resulting word in the data register. It assumes
// WIN_LO <= WIN_HI < PULSE_CYC, and that the sense inputs are synchronous
// to clk.
module core_stack_ctrl #(
    parameter int PLANES    = 8,
    parameter int XW        = 6,
    parameter int YW        = 6,
    parameter int PULSE_CYC = 4,
    parameter int GAP_CYC   = 2,
    parameter int WIN_LO    = 1,
    parameter int WIN_HI    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [XW+YW-1:0]  addr,
    input  logic [PLANES-1:0] wdata,
    output logic [PLANES-1:0] rdata,
    output logic              ready,
    output logic [XW-1:0]     col_sel,
    output logic [YW-1:0]     row_sel,
    output logic [PLANES-1:0] plane_drv,
    output logic              drive_one,
    input  logic [PLANES-1:0] sense
);
    localparam int            CMAX = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
    localparam int            CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] WLO  = CW'(WIN_LO);
    localparam logic [CW-1:0] WHI  = CW'(WIN_HI);

    logic              idle;
    logic              accept;
    logic              in_clear;
    logic [CW-1:0]     cnt;
    logic              we_q;
    logic              cap_en;
    logic [PLANES-1:0] data_next;

    assign accept = req && idle;
    assign ready  = idle;
    assign cap_en = in_clear && !we_q && (cnt >= WLO) && (cnt <= WHI);

    // Latch address and direction when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_sel <= '0;
            row_sel <= '0;
            we_q    <= 1'b0;
        end else if (accept) begin
            col_sel <= addr[XW+YW-1:YW];
            row_sel <= addr[YW-1:0];
            we_q    <= we;
        end
    end

    cs_sense_latch #(.PLANES(PLANES)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_val  (we ? wdata : '0),
        .cap_en    (cap_en),
        .sense     (sense),
        .data_q    (rdata),
        .data_next (data_next)
    );

    cs_sequencer #(
        .PLANES    (PLANES),
        .PULSE_CYC (PULSE_CYC),
        .GAP_CYC   (GAP_CYC),
        .CW        (CW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .pend_src  (data_next),
        .idle      (idle),
        .in_clear  (in_clear),
        .cnt       (cnt),
        .plane_drv (plane_drv),
        .drive_one (drive_one)
    );

    // R3: while idle, nothing is driven into the stack.
    a_r3_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (plane_drv == '0));

    // R1: the select lines stay put for the whole access.
    a_r1_select_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !$past(ready)) |-> ($stable(col_sel) && $stable(row_sel)));

    // R7: a one is only driven into a plane whose data bit is set.
    a_r7_restore_only_ones: assert property (@(posedge clk) disable iff (!rst_n)
        drive_one |-> ((plane_drv & ~rdata) == '0));
endmodule

// File: tb/core_stack_ctrl_test.sv
`timescale 1ns/1ps
module core_stack_ctrl_test;
    localparam int P    = 4;
    localparam int G    = 2;
    localparam int WLO  = 1;
    localparam int WHI  = 2;
    localparam int SLOT = P + G;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  sense = '0;
    logic [7:0]  rdata;
    logic        ready;
    logic [5:0]  col_sel;
    logic [5:0]  row_sel;
    logic [7:0]  plane_drv;
    logic        drive_one;

    int checks = 0;
    int fails  = 0;
    logic [7:0] mem [int];

    always #4 clk = ~clk;

    core_stack_ctrl #(.PULSE_CYC(P), .GAP_CYC(G), .WIN_LO(WLO), .WIN_HI(WHI)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ready(ready), .col_sel(col_sel), .row_sel(row_sel),
        .plane_drv(plane_drv), .drive_one(drive_one), .sense(sense)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] peek(input logic [11:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
    endfunction

    // Plane index of the j-th set bit (j from 0), ascending.
    function automatic int nth_one(input logic [7:0] v, input int j);
        int c = 0;
        for (int i = 0; i < 8; i++) begin
            if (v[i]) begin
                if (c == j) return i;
                c++;
            end
        end
        return -1;
    endfunction

    // Run one access; check the drive schedule cycle by cycle, the busy
    // length, rdata, and the modelled core contents afterwards.
    // oow: sense pulses only outside the window. spur: hold req mid-access.
    task automatic do_op(input bit w, input logic [11:0] a, input logic [7:0] wd,
                         input bit oow, input bit spur, input string rq);
        logic [7:0] stored = peek(a);
        logic [7:0] pend   = w ? wd : (oow ? 8'h00 : stored);
        int n = $countones(pend);
        int busy_exp = (n + 1) * SLOT;
        int bad = 0;
        int busy = -1;
        logic [7:0] exp_en;
        logic       exp_one;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = wd;
        @(negedge clk);
        req = 1'b0; addr = 12'hFFF - a; wdata = ~wd;
        for (int k = 0; k < 200; k++) begin
            int seg = k / SLOT;
            int off = k % SLOT;
            exp_en = 8'h00; exp_one = 1'b0;
            if (off < P && k < busy_exp) begin
                if (seg == 0) exp_en = 8'hFF;
                else begin exp_en = 8'h01 << nth_one(pend, seg - 1); exp_one = 1'b1; end
            end
            if (ready) begin busy = k; sense = 8'h00; break; end
            if (plane_drv != exp_en || drive_one != exp_one ||
                col_sel != a[11:6] || row_sel != a[5:0]) begin
                if (bad == 0)
                    $display("FAIL %s schedule cycle %0d: actual drv 0x%0h one %0b sel %0h/%0h expected drv 0x%0h one %0b sel %0h/%0h",
                             rq, k, plane_drv, drive_one, col_sel, row_sel, exp_en, exp_one, a[11:6], a[5:0]);
                bad++;
            end
            // Core model: a driven plane takes the drive polarity.
            if (plane_drv != 8'h00 && k < busy_exp) begin
                logic [7:0] m = peek(a);
                for (int p = 0; p < 8; p++) if (plane_drv[p]) m[p] = drive_one;
                mem[int'(a)] = m;
            end
            // Sense pulses appear for flipping cores (also during writes).
            if (oow) sense = (k == 0 || k == P - 1) ? 8'hFF : 8'h00;
            else     sense = (k >= WLO && k <= WHI) ? stored : 8'h00;
            if (spur) begin
                if (k == 3) req = 1'b1;
                if (k == busy_exp - 2) req = 1'b0;
            end
            @(negedge clk);
        end
        req = 1'b0;
        checks++;
        if (bad != 0) fails++;
        check(busy == busy_exp, "R8", "busy cycles", busy, busy_exp);
        check(rdata == (w ? wd : pend), w ? "R9" : "R6", "rdata", rdata, w ? wd : pend);
        check(peek(a) == (w ? wd : stored), w ? "R9" : "R7", "core contents",
              peek(a), w ? wd : stored);
    endtask

    task automatic t_reset;
        // R2: reset state.
        check(ready == 1'b1, "R2", "ready", ready, 1);
        check(plane_drv == 8'h00, "R2", "plane_drv", plane_drv, 0);
        check(rdata == 8'h00, "R2", "rdata", rdata, 0);
    endtask

    task automatic t_write_read;
        // R9 then R6/R7: write a pattern, read it back twice (restore works).
        do_op(1'b1, 12'h5C3, 8'hA5, 1'b0, 1'b0, "R9");
        do_op(1'b0, 12'h5C3, 8'h00, 1'b0, 1'b0, "R6");
        do_op(1'b0, 12'h5C3, 8'h00, 1'b0, 1'b0, "R7");
    endtask

    task automatic t_extremes;
        // R4/R8: zero word needs only the clear slot; all ones needs eight restores.
        do_op(1'b1, 12'h001, 8'h00, 1'b0, 1'b0, "R4");
        do_op(1'b0, 12'h001, 8'h00, 1'b0, 1'b0, "R4");
        do_op(1'b1, 12'hFC0, 8'hFF, 1'b0, 1'b0, "R8");
        do_op(1'b0, 12'hFC0, 8'h00, 1'b0, 1'b0, "R7");
        do_op(1'b1, 12'h03F, 8'h80, 1'b0, 1'b0, "R7");
        do_op(1'b0, 12'h03F, 8'h00, 1'b0, 1'b0, "R7");
    endtask

    task automatic t_window;
        // R5: pulses only outside the sampling window are ignored.
        do_op(1'b0, 12'h2AA, 8'h00, 1'b1, 1'b0, "R5");
        check(rdata == 8'h00, "R5", "out-of-window rdata", rdata, 0);
    endtask

    task automatic t_busy_req;
        // R3/R1: a request held during an access neither moves the selects
        // nor starts a second access.
        do_op(1'b1, 12'h7E1, 8'h3C, 1'b0, 1'b0, "R3");
        do_op(1'b0, 12'h7E1, 8'h00, 1'b0, 1'b1, "R1");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(ready == 1'b1 && plane_drv == 8'h00, "R3", "idle after access",
                  {ready, plane_drv}, 9'h100);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_extremes();
        t_window();
        t_busy_req();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule